// File: doc/BRIEF.md
# Opcode Page Stack Controller

This block keeps track of which opcode page a 16-bit compressed instruction decoder uses for its 11-bit payload. Page-select events push a subpage number and an activation length onto a four-entry stack. The top entry is the active page. When the stack is empty, the default base encoding is in force. Each retired ordinary instruction counts down the top entry's length, and an entry whose length runs out is removed. The all-ones length code keeps a page active with no countdown. A taken branch ends a finite selection.

Every subpage provides two page-control instructions. One clears the whole stack and returns straight to the default encoding. The other removes only the top entry. The complete stack state is held in a single CSR-sized register image, so calling code can save the state around a function call and restore it afterwards. The decoder uses only the two outputs: the active subpage number and the base-mode flag.

Top module: `opstk_ctrl`

## Requirements
- R1: After synchronous reset, the depth is 0, `base_mode` is 1, `active_page` is 0 and `csr_rdata` is all zeros.
- R2: A select event with a length from 1 to 15 pushes the entry {page, length} and raises the depth by one. On the next cycle `active_page` shows the new page and `base_mode` is 0. `base_mode` is 1 exactly when the depth field of `csr_rdata` is 0.
- R3: A select event with length 0 is ignored, and the stack and outputs stay unchanged.
- R4: The depth never exceeds 4. A select at depth 4 overwrites entry 3 and leaves the depth at 4.
- R5: A retire event with no control event in the same cycle works on the top entry when that entry's length is finite. A length above 1 is decremented. A length of 1 or 0 pops the entry, which is then stored as zero. A retire at depth 0 has no effect.
- R6: A top entry with length 15 (all ones) is permanent, and retire events leave it unchanged.
- R7: A pop event removes the top entry, zeroes it and restores the previous page. A pop at depth 0 has no effect.
- R8: A clear event zeroes every entry and the depth, which restores the default encoding.
- R9: A taken branch clears the whole stack when the top entry has a finite length. It has no effect when the top entry is permanent or the depth is 0.
- R10: In `csr_rdata`, entry i has its page in bits [7i+2:7i] and its length in bits [7i+6:7i+3], entry 0 lowest. The depth is in bits [30:28] and bit 31 reads 0. The value reflects the current state with no added delay.
- R11: A CSR write loads the stack from `csr_wdata` on the next clock edge and is not visible in the same cycle. Bit 31 is discarded, and a depth field above 4 is stored as 4.
- R12: When several events arrive in one cycle, only one acts, in this priority: CSR write, clear, branch, select, pop, retire. A retire that coincides with any other event is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_valid | input | 1 | Page-select event |
| sel_page | input | 3 | Subpage number for a select |
| sel_len | input | 4 | Activation length for a select (15 = permanent) |
| pop_valid | input | 1 | Remove-top event |
| clear_valid | input | 1 | Return-to-default event |
| branch_taken | input | 1 | A branch was taken |
| retire_valid | input | 1 | An ordinary instruction retired |
| csr_we | input | 1 | Write the state image |
| csr_wdata | input | 32 | State image to load |
| csr_rdata | output | 32 | Current state image |
| active_page | output | 3 | Subpage of the top entry, 0 when the stack is empty |
| base_mode | output | 1 | Default encoding is in force (stack empty) |

## Verification
The hardest situations to reach from the ports are a full stack whose top is overwritten, and a countdown expiring several levels down so that an older finite page is uncovered. Reaching them takes a chain of nested selects, and each retire or pop must land on a known top length. The stimulus table builds that nest step by step, with the expected image written out at every step. Directed writes then load states that selects alone cannot produce, such as an out-of-range depth with every bit set. They also put events in the same cycle to exercise the priority order.

// File: rtl/opstk_pkg.sv
package opstk_pkg;
    localparam int NUM_ENTRIES = 4;
    localparam int PAGE_W      = 3;
    localparam int LEN_W       = 4;
    localparam int DEPTH_W     = 3;
    localparam int CSR_W       = 32;

    localparam int ENTRY_W   = PAGE_W + LEN_W;
    localparam int IDX_W     = $clog2(NUM_ENTRIES);
    localparam int DEPTH_LSB = NUM_ENTRIES * ENTRY_W;
    localparam int IMG_W     = DEPTH_LSB + DEPTH_W;

    localparam logic [LEN_W-1:0]   LEN_PERM  = '1;
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(NUM_ENTRIES);

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [PAGE_W-1:0] page;
    } entry_t;

    typedef struct packed {
        logic [DEPTH_W-1:0]               depth;
        entry_t [NUM_ENTRIES-1:0]         ent;
    } stack_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_CSR,
        EV_CLEAR,
        EV_BRANCH,
        EV_SELECT,
        EV_POP,
        EV_RETIRE
    } event_e;

    // Fixed arbitration between simultaneous events.
    function automatic event_e pick_event(input logic we, input logic clr,
                                          input logic br, input logic sel,
                                          input logic pop, input logic ret);
        if (we)       return EV_CSR;
        else if (clr) return EV_CLEAR;
        else if (br)  return EV_BRANCH;
        else if (sel) return EV_SELECT;
        else if (pop) return EV_POP;
        else if (ret) return EV_RETIRE;
        else          return EV_NONE;
    endfunction

    function automatic logic [IDX_W-1:0] top_index(input logic [DEPTH_W-1:0] d);
        logic [DEPTH_W-1:0] t;
        t = d - 1'b1;
        return t[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/opstk_csr_codec.sv
module opstk_csr_codec
    import opstk_pkg::*;
(
    input  stack_t            cur,
    input  logic [CSR_W-1:0]  wdata,
    output logic [CSR_W-1:0]  rdata,
    output stack_t            wr_state
);
    entry_t [NUM_ENTRIES-1:0] wr_ent;
    logic   [DEPTH_W-1:0]     wr_depth_raw;
    logic   [DEPTH_W-1:0]     wr_depth;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
        assign rdata[i*ENTRY_W +: ENTRY_W] = cur.ent[i];
        assign wr_ent[i]                   = wdata[i*ENTRY_W +: ENTRY_W];
    end

    assign rdata[DEPTH_LSB +: DEPTH_W] = cur.depth;
    assign rdata[CSR_W-1:IMG_W]        = '0;

    assign wr_depth_raw = wdata[DEPTH_LSB +: DEPTH_W];
    assign wr_depth     = (wr_depth_raw > DEPTH_MAX) ? DEPTH_MAX : wr_depth_raw;
    assign wr_state     = {wr_depth, wr_ent};
endmodule

// File: rtl/opstk_next.sv
module opstk_next
    import opstk_pkg::*;
(
    input  stack_t  cur,
    input  event_e  ev,
    input  entry_t  sel_ent,
    input  stack_t  csr_state,
    output stack_t  nxt
);
    logic [IDX_W-1:0] top;
    logic             empty;
    logic             full;
    logic             top_finite;

    always_comb begin
        top        = top_index(cur.depth);
        empty      = (cur.depth == '0);
        full       = (cur.depth == DEPTH_MAX);
        top_finite = !empty && (cur.ent[top].len != LEN_PERM);
        nxt        = cur;
        unique case (ev)
            EV_CSR:   nxt = csr_state;
            EV_CLEAR: nxt = '0;
            EV_BRANCH: begin
                if (top_finite) nxt = '0;
            end
            EV_SELECT: begin
                if (sel_ent.len != '0) begin
                    if (full) begin
                        nxt.ent[NUM_ENTRIES-1] = sel_ent;
                    end else begin
                        nxt.ent[cur.depth[IDX_W-1:0]] = sel_ent;
                        nxt.depth = cur.depth + 1'b1;
                    end
                end
            end
            EV_POP: begin
                if (!empty) begin
                    nxt.ent[top] = '0;
                    nxt.depth    = cur.depth - 1'b1;
                end
            end
            EV_RETIRE: begin
                if (top_finite) begin
                    if (cur.ent[top].len <= LEN_W'(1)) begin
                        nxt.ent[top] = '0;
                        nxt.depth    = cur.depth - 1'b1;
                    end else begin
                        nxt.ent[top].len = cur.ent[top].len - 1'b1;
                    end
                end
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/opstk_ctrl.sv
module opstk_ctrl
    import opstk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_valid,
    input  logic [PAGE_W-1:0]    sel_page,
    input  logic [LEN_W-1:0]     sel_len,
    input  logic                 pop_valid,
    input  logic                 clear_valid,
    input  logic                 branch_taken,
    input  logic                 retire_valid,
    input  logic                 csr_we,
    input  logic [CSR_W-1:0]     csr_wdata,
    output logic [CSR_W-1:0]     csr_rdata,
    output logic [PAGE_W-1:0]    active_page,
    output logic                 base_mode
);
    localparam logic [CSR_W-1:0] IMG_MASK = CSR_W'((64'd1 << IMG_W) - 64'd1);

    stack_t state_q;
    stack_t state_d;
    stack_t csr_state;
    event_e ev;
    entry_t sel_ent;
    entry_t top_ent;

    assign ev      = pick_event(csr_we, clear_valid, branch_taken,
                                sel_valid, pop_valid, retire_valid);
    assign sel_ent = '{len: sel_len, page: sel_page};

    opstk_csr_codec u_codec (
        .cur      (state_q),
        .wdata    (csr_wdata),
        .rdata    (csr_rdata),
        .wr_state (csr_state)
    );

    opstk_next u_next (
        .cur       (state_q),
        .ev        (ev),
        .sel_ent   (sel_ent),
        .csr_state (csr_state),
        .nxt       (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign top_ent     = state_q.ent[top_index(state_q.depth)];
    assign base_mode   = (state_q.depth == '0);
    assign active_page = base_mode ? '0 : top_ent.page;

    // Stack never grows beyond its capacity.
    assert_depth_bound_R4: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[DEPTH_LSB +: DEPTH_W] <= DEPTH_MAX);

    // Base flag agrees with the depth field of the image.
    assert_base_flag_R2: assert property (@(posedge clk) disable iff (rst)
        base_mode == (csr_rdata[DEPTH_LSB +: DEPTH_W] == '0));

    // Clear event empties the stack.
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_CLEAR) |=> (base_mode && csr_rdata == '0));

    // Pop on an empty stack changes nothing.
    assert_pop_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_POP && base_mode) |=> $stable(csr_rdata));

    // Permanent top ignores retires.
    assert_perm_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_RETIRE && !base_mode && top_ent.len == LEN_PERM) |=> $stable(csr_rdata));

    // Branch over a finite top returns to default.
    assert_branch_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_BRANCH && !base_mode && top_ent.len != LEN_PERM) |=> base_mode);

    // In-range write is read back one cycle later, top bit dropped.
    assert_csr_load_R11: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_wdata[DEPTH_LSB +: DEPTH_W] <= DEPTH_MAX)
        |=> (csr_rdata == ($past(csr_wdata) & IMG_MASK)));

    // Out-of-range depth is saturated.
    assert_csr_clamp_R11: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_wdata[DEPTH_LSB +: DEPTH_W] > DEPTH_MAX)
        |=> (csr_rdata[DEPTH_LSB +: DEPTH_W] == DEPTH_MAX));
endmodule

// File: tb/tb_opstk_ctrl.sv
module tb_opstk_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        sel_valid, pop_valid, clear_valid, branch_taken, retire_valid, csr_we;
    logic [2:0]  sel_page;
    logic [3:0]  sel_len;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic [2:0]  active_page;
    logic        base_mode;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    opstk_ctrl dut (
        .clk(clk), .rst(rst),
        .sel_valid(sel_valid), .sel_page(sel_page), .sel_len(sel_len),
        .pop_valid(pop_valid), .clear_valid(clear_valid),
        .branch_taken(branch_taken), .retire_valid(retire_valid),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .active_page(active_page), .base_mode(base_mode)
    );

    // ctl bits: {select, pop, clear, branch, retire}
    typedef struct packed {
        logic [4:0]  ctl;
        logic [2:0]  page;
        logic [3:0]  len;
        logic [2:0]  exp_page;
        logic        exp_base;
        logic [31:0] exp_csr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{5'b10000, 3'd3, 4'd2,  3'd3, 1'b0, 32'h1000_0013, 4'd2},  // R2 push
        '{5'b00001, 3'd0, 4'd0,  3'd3, 1'b0, 32'h1000_000B, 4'd5},  // R5 decrement
        '{5'b00001, 3'd0, 4'd0,  3'd0, 1'b1, 32'h0000_0000, 4'd5},  // R5 expire pop
        '{5'b10000, 3'd5, 4'd15, 3'd5, 1'b0, 32'h1000_007D, 4'd6},  // R6 permanent push
        '{5'b00001, 3'd0, 4'd0,  3'd5, 1'b0, 32'h1000_007D, 4'd6},  // R6 retire held
        '{5'b10000, 3'd2, 4'd3,  3'd2, 1'b0, 32'h2000_0D7D, 4'd2},  // R2 nest
        '{5'b10000, 3'd0, 4'd0,  3'd2, 1'b0, 32'h2000_0D7D, 4'd3},  // R3 zero length
        '{5'b10000, 3'd7, 4'd1,  3'd7, 1'b0, 32'h3003_CD7D, 4'd10}, // R10 layout
        '{5'b10000, 3'd1, 4'd4,  3'd1, 1'b0, 32'h4423_CD7D, 4'd10}, // R10 full
        '{5'b10000, 3'd6, 4'd5,  3'd6, 1'b0, 32'h45C3_CD7D, 4'd4},  // R4 overwrite
        '{5'b01000, 3'd0, 4'd0,  3'd7, 1'b0, 32'h3003_CD7D, 4'd7},  // R7 pop
        '{5'b00001, 3'd0, 4'd0,  3'd2, 1'b0, 32'h2000_0D7D, 4'd5},  // R5 expire deep
        '{5'b10001, 3'd4, 4'd2,  3'd4, 1'b0, 32'h3005_0D7D, 4'd12}, // R12 retire lost
        '{5'b00010, 3'd0, 4'd0,  3'd0, 1'b1, 32'h0000_0000, 4'd9},  // R9 finite branch
        '{5'b10000, 3'd5, 4'd15, 3'd5, 1'b0, 32'h1000_007D, 4'd2},  // R2
        '{5'b00010, 3'd0, 4'd0,  3'd5, 1'b0, 32'h1000_007D, 4'd9},  // R9 permanent
        '{5'b11000, 3'd1, 4'd1,  3'd1, 1'b0, 32'h2000_04FD, 4'd12}, // R12 select over pop
        '{5'b00100, 3'd0, 4'd0,  3'd0, 1'b1, 32'h0000_0000, 4'd8},  // R8 clear
        '{5'b01000, 3'd0, 4'd0,  3'd0, 1'b1, 32'h0000_0000, 4'd7},  // R7 empty pop
        '{5'b00010, 3'd0, 4'd0,  3'd0, 1'b1, 32'h0000_0000, 4'd9},  // R9 empty branch
        '{5'b00001, 3'd0, 4'd0,  3'd0, 1'b1, 32'h0000_0000, 4'd5}   // R5 empty retire
    };

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sel_valid = 0; pop_valid = 0; clear_valid = 0; branch_taken = 0;
        retire_valid = 0; csr_we = 0; sel_page = '0; sel_len = '0; csr_wdata = '0;
    endtask

    task automatic expect_state(input int req, input logic [31:0] ecsr,
                                input logic [2:0] epg, input logic ebase);
        check(csr_rdata == ecsr, req, "image", csr_rdata, ecsr);
        check(active_page == epg, req, "page", 32'(active_page), 32'(epg));
        check(base_mode == ebase, req, "base", 32'(base_mode), 32'(ebase));
    endtask

    // Drive at a falling edge, hold across one rising edge, check at the next falling edge.
    task automatic csr_write(input logic [31:0] v, input logic also_clear);
        csr_we = 1; csr_wdata = v; clear_valid = also_clear;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        expect_state(1, 32'h0, 3'd0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            {sel_valid, pop_valid, clear_valid, branch_taken, retire_valid} = VECS[i].ctl;
            sel_page = VECS[i].page;
            sel_len  = VECS[i].len;
            @(posedge clk);
            @(negedge clk);
            idle_inputs();
            expect_state(int'(VECS[i].req), VECS[i].exp_csr, VECS[i].exp_page, VECS[i].exp_base);
        end

        // R11 write not visible in the same cycle, then clamp and top-bit drop
        csr_we = 1; csr_wdata = 32'hFFFF_FFFF;
        #1;
        check(csr_rdata == 32'h0, 11, "same-cycle image", csr_rdata, 32'h0);
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        expect_state(11, 32'h4FFF_FFFF, 3'd7, 1'b0);

        // R10 restore a saved image; top is entry 1
        csr_write(32'h2000_0D7D, 1'b0);
        expect_state(10, 32'h2000_0D7D, 3'd2, 1'b0);

        // R5 retire on restored finite top: length 3 -> 2
        retire_valid = 1;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        expect_state(5, 32'h2000_097D, 3'd2, 1'b0);

        // R12 CSR write beats a clear in the same cycle
        csr_write(32'h1000_0013, 1'b1);
        expect_state(12, 32'h1000_0013, 3'd3, 1'b0);

        // R1 reset again from a non-empty state
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        expect_state(1, 32'h0, 3'd0, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule